// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flags and Alarm Unit

This block raises the interrupt request of a real-time clock and holds the flags register that the clock's events share. It keeps one interrupt-control register and four alarm registers. It makes a programmable periodic event out of two sources: a 32,768 Hz clock enable and the hundredths-of-a-second tick. Once per second, when the clock counters update, it compares the alarm against the current BCD time. The interrupt request is open-drain style and active low.

Software reaches the registers through a small select/strobe port. A read of the flags register returns every pending flag and clears them all at once, which also releases the interrupt. Events from outside the block set their own flags directly: watchdog timeout, power failure and battery low.

Outside this block are the time-keeping counters, which supply the BCD time bytes and the per-second update strobe, and the watchdog, which supplies a timeout pulse.

Top module: `rtc_irq_alarm`

## Requirements
- R1: After reset, every register reads 0x00, `irq_oe` is 0 and `irq_n` is 1.
- R2: Register select codes are 0 for control, 1 to 4 for the alarm seconds, minutes, hours and date, and 5 for flags. Codes 6 and 7 read 0x00. The control byte is laid out from bit 7 down as alarm enable, power-fail enable, battery-backup alarm enable, periodic enable, then the 4-bit rate code in bits 3..0. Control and alarm registers read back what was written.
- R3: The flags byte is laid out from bit 7 down as watchdog, alarm, power-fail, battery-low, periodic. Bits 2..0 always read 0.
- R4: Every event sets its flag whatever the enables hold. Outside battery-backup mode, `irq_oe` is 1 exactly when at least one of the alarm, power-fail and periodic flags is set together with its own enable bit. The watchdog and battery-low flags never drive the interrupt.
- R5: A read of the flags register returns the flags as they stood and clears all of them from the next cycle. The interrupt is then released. An event in the same cycle as the read survives the clear.
- R6: For a rate code c from 3 to 15, the periodic event fires on every 2^(c-1)th `tick_32k` pulse counted since reset. Code 3 gives every 4th pulse and code 15 every 16384th.
- R7: Rate code 1 fires on every `tick_hund` pulse. Code 2 fires on every 10th `tick_hund` pulse counted since reset. Code 0 never fires.
- R8: Bit 7 of each alarm byte is a "don't care" mask for that field. Bits 6..0 of each unmasked field must equal bits 6..0 of the matching time input. Masks 1111 (date, hours, minutes, seconds) give an alarm every second, 1110 give one on a seconds match, 1100 on minutes and seconds, 1000 on hours, minutes and seconds, and 0000 on a full date and time match.
- R9: The alarm is compared only in a cycle where `sec_update` is 1. A matching time without that strobe sets no flag.
- R10: While `por_active` is 1, the four enable bits are held at 0 and writes to them are ignored, while the rate field still takes writes. An alarm in this time sets only its flag.
- R11: While `batt_mode` is 1, `irq_oe` is 1 only when the alarm flag, the alarm enable and the battery-backup alarm enable are all set. Power-fail and periodic requests are released.
- R12: Pulses on `wdog_evt`, `pwr_fail` and `batt_low` set flag bits 7, 5 and 4 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_32k | input | 1 | One-cycle enable at 32,768 Hz |
| tick_hund | input | 1 | One-cycle enable every hundredth of a second |
| sec_update | input | 1 | Once-per-second time update strobe |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD, 24-hour |
| cur_date | input | 8 | Current date, BCD |
| wdog_evt | input | 1 | Watchdog timeout pulse |
| pwr_fail | input | 1 | Power-fail detect pulse |
| batt_low | input | 1 | Battery-low detect pulse |
| batt_mode | input | 1 | Battery-backup mode |
| por_active | input | 1 | Power-on reset window in progress |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_sel` |
| irq_n | output | 1 | Interrupt level, low while driven |
| irq_oe | output | 1 | Interrupt output enable |

## Verification
The assertions check the following on every cycle:
- a flags read with no coinciding event leaves the flags empty;
- an alarm or periodic event always leaves its flag set;
- rate code 0 stays quiet;
- the power-on window keeps the enables at zero;
- battery-backup mode suppresses every request except an enabled alarm;
- an alarm match occurs only on an update strobe.

Only the bench's scenarios can show whether each rate code has the right period, with offsets counted from reset, and which alarm fields a given mask pattern compares. The bench checks the alarm masks across random alarm values and times.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

  localparam int RATE_W = 4;
  localparam int NFIELD = 4;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_ASEC  = 3'd1,
    SEL_AMIN  = 3'd2,
    SEL_AHOUR = 3'd3,
    SEL_ADATE = 3'd4,
    SEL_FLAGS = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic              aie;
    logic              pwrie;
    logic              abe;
    logic              pie;
    logic [RATE_W-1:0] rate;
  } ictrl_t;

  typedef struct packed {
    logic wdog;
    logic alarm;
    logic pfail;
    logic blow;
    logic per;
  } flags_t;

  // One alarm field: bit 7 masks the field, else bits 6..0 must agree.
  function automatic logic field_hit(input logic [7:0] alm, input logic [7:0] now);
    return alm[7] | (alm[6:0] == now[6:0]);
  endfunction

endpackage

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen
  import rtc_irq_pkg::*;
#(
  parameter int DEC_DIV = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_bin,
  input  logic              tick_dec,
  input  logic [RATE_W-1:0] rate,
  output logic              per_evt
);
  localparam int NCODE = 2 ** RATE_W;
  localparam int DIV_W = NCODE - 2;
  localparam int DEC_W = $clog2(DEC_DIV);

  logic [DIV_W-1:0] div_q;
  logic [DEC_W-1:0] dec_q;
  logic [NCODE-1:0] bin_hit;
  logic             dec_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      dec_q <= '0;
    end else begin
      if (tick_bin) div_q <= div_q + 1'b1;
      if (tick_dec) dec_q <= dec_wrap ? '0 : dec_q + 1'b1;
    end
  end

  assign dec_wrap = (dec_q == DEC_W'(DEC_DIV - 1));

  // Binary-fraction codes: code c fires when the low c-1 divider bits are all ones.
  assign bin_hit[2:0] = '0;
  for (genvar c = 3; c < NCODE; c++) begin : g_bin
    assign bin_hit[c] = tick_bin & (&div_q[c-2:0]);
  end

  always_comb begin
    unique case (rate)
      RATE_W'(0): per_evt = 1'b0;
      RATE_W'(1): per_evt = tick_dec;
      RATE_W'(2): per_evt = tick_dec & dec_wrap;
      default:    per_evt = bin_hit[rate];
    endcase
  end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_irq_pkg::*;
(
  input  logic                   sec_update,
  input  logic [NFIELD-1:0][7:0] alm,
  input  logic [NFIELD-1:0][7:0] now,
  output logic                   alm_evt
);
  logic [NFIELD-1:0] hit;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    assign hit[i] = field_hit(alm[i], now[i]);
  end

  assign alm_evt = sec_update & (&hit);

endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank
  import rtc_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t set,
  input  logic   clr,
  output flags_t flags_q
);
  // Clear first, then merge new events so a coincident event is kept.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (clr ? flags_t'('0) : flags_q) | set;
  end

endmodule

// File: rtl/rtc_irq_alarm.sv
module rtc_irq_alarm
  import rtc_irq_pkg::*;
#(
  parameter int DEC_DIV = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       tick_hund,
  input  logic       sec_update,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] cur_date,
  input  logic       wdog_evt,
  input  logic       pwr_fail,
  input  logic       batt_low,
  input  logic       batt_mode,
  input  logic       por_active,
  input  logic [2:0] reg_sel,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_n,
  output logic       irq_oe
);
  ictrl_t                   ctrl_q, ctrl_d;
  logic [NFIELD-1:0][7:0]   alm_q;
  logic [NFIELD-1:0][7:0]   now_v;
  flags_t                   flags_q, flag_set;
  logic                     per_evt, alm_evt, flag_clr, set_any;
  logic                     req_norm, req_batt;
  logic [3:0]               ctrl_en;

  always_comb begin
    ctrl_d = ctrl_q;
    if (reg_wr && reg_sel == SEL_CTRL) ctrl_d = ictrl_t'(reg_wdata);
    if (por_active) begin
      ctrl_d.aie   = 1'b0;
      ctrl_d.pwrie = 1'b0;
      ctrl_d.abe   = 1'b0;
      ctrl_d.pie   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      alm_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (reg_wr) begin
        unique case (reg_sel)
          SEL_ASEC:  alm_q[0] <= reg_wdata;
          SEL_AMIN:  alm_q[1] <= reg_wdata;
          SEL_AHOUR: alm_q[2] <= reg_wdata;
          SEL_ADATE: alm_q[3] <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  assign now_v = {cur_date, cur_hour, cur_min, cur_sec};

  rtc_rate_gen #(.DEC_DIV(DEC_DIV)) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_bin (tick_32k),
    .tick_dec (tick_hund),
    .rate     (ctrl_q.rate),
    .per_evt  (per_evt)
  );

  rtc_alarm_match u_alarm (
    .sec_update (sec_update),
    .alm        (alm_q),
    .now        (now_v),
    .alm_evt    (alm_evt)
  );

  assign flag_set = '{wdog: wdog_evt, alarm: alm_evt, pfail: pwr_fail,
                      blow: batt_low, per: per_evt};
  assign set_any  = |flag_set;
  assign flag_clr = reg_rd && (reg_sel == SEL_FLAGS);

  rtc_flag_bank u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (flag_set),
    .clr     (flag_clr),
    .flags_q (flags_q)
  );

  assign req_norm = (flags_q.alarm & ctrl_q.aie) |
                    (flags_q.pfail & ctrl_q.pwrie) |
                    (flags_q.per   & ctrl_q.pie);
  assign req_batt = flags_q.alarm & ctrl_q.aie & ctrl_q.abe;
  assign irq_oe   = batt_mode ? req_batt : req_norm;
  assign irq_n    = ~irq_oe;
  assign ctrl_en  = {ctrl_q.aie, ctrl_q.pwrie, ctrl_q.abe, ctrl_q.pie};

  always_comb begin
    unique case (reg_sel)
      SEL_CTRL:  reg_rdata = ctrl_q;
      SEL_ASEC:  reg_rdata = alm_q[0];
      SEL_AMIN:  reg_rdata = alm_q[1];
      SEL_AHOUR: reg_rdata = alm_q[2];
      SEL_ADATE: reg_rdata = alm_q[3];
      SEL_FLAGS: reg_rdata = {flags_q, 3'b000};
      default:   reg_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       batt_mode,
  input logic       por_active,
  input logic       sec_update,
  input logic       irq_oe,
  input logic       flag_clr,
  input logic       set_any,
  input logic [4:0] flags_q,
  input logic       alm_evt,
  input logic       per_evt,
  input logic [3:0] ctrl_en,
  input logic [3:0] rate
);
  // R5
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !set_any) |=> (flags_q == 5'b0));

  // R4
  alarm_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alm_evt |=> flags_q[3]);

  // R6
  periodic_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |=> flags_q[0]);

  // R7
  rate_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == 4'd0) |-> !per_evt);

  // R10
  por_enables_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_active |=> (ctrl_en == 4'b0));

  // R11
  batt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_mode && !(ctrl_en[3] && ctrl_en[1])) |-> !irq_oe);

  // R4
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> (flags_q[3] || flags_q[2] || flags_q[0]));

  // R9
  alarm_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alm_evt |-> sec_update);

endmodule

bind rtc_irq_alarm rtc_irq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .batt_mode  (batt_mode),
  .por_active (por_active),
  .sec_update (sec_update),
  .irq_oe     (irq_oe),
  .flag_clr   (flag_clr),
  .set_any    (set_any),
  .flags_q    (flags_q),
  .alm_evt    (alm_evt),
  .per_evt    (per_evt),
  .ctrl_en    (ctrl_en),
  .rate       (ctrl_q.rate)
);

// File: tb/tb_rtc_irq_alarm.sv
module tb_rtc_irq_alarm;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_32k = 0, tick_hund = 0, sec_update = 0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_date = 0;
  logic wdog_evt = 0, pwr_fail = 0, batt_low = 0, batt_mode = 0, por_active = 0;
  logic [2:0] reg_sel = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic irq_n, irq_oe;

  int n_chk = 0, n_bad = 0;
  int n32 = 0, nh = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_irq_alarm dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  // 0 wdog, 1 pfail, 2 blow, 3 sec_update, 4 tick_32k, 5 tick_hund
  task automatic pulse(input int k);
    @(negedge clk);
    case (k)
      0: wdog_evt = 1; 1: pwr_fail = 1; 2: batt_low = 1;
      3: sec_update = 1; 4: begin tick_32k = 1; n32++; end
      default: begin tick_hund = 1; nh++; end
    endcase
    @(negedge clk);
    {wdog_evt, pwr_fail, batt_low, sec_update, tick_32k, tick_hund} = '0;
  endtask

  function automatic int bin_period(input int code);
    int p = 1;
    for (int i = 1; i < code; i++) p = p * 2;
    return p;
  endfunction

  function automatic bit exp_alarm(input logic [3:0] m, input logic [7:0] a[4],
                                   input logic [7:0] t[4]);
    for (int i = 0; i < 4; i++)
      if (!m[i] && (a[i] % 128) != (t[i] % 128)) return 0;
    return 1;
  endfunction

  task automatic set_time(input logic [7:0] t[4]);
    cur_sec = t[0]; cur_min = t[1]; cur_hour = t[2]; cur_date = t[3];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] a[4], t[4];
    logic [3:0] m;
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int s = 0; s < 8; s++) begin rd(3'(s), d); chk("R1 reg", d, 0); end
    chk("R1 irq_oe", irq_oe, 0);
    chk("R1 irq_n", irq_n, 1);

    // R2 readback
    wr(0, 8'hA5); rd(0, d); chk("R2 ctrl", d, 8'hA5);
    wr(3, 8'h9C); rd(3, d); chk("R2 alarm hour", d, 8'h9C);
    wr(6, 8'h77); rd(6, d); chk("R2 unused sel", d, 0);
    wr(0, 8'h00);

    // R12 / R3 external flags
    pulse(0); pulse(1); pulse(2);
    rd(5, d); chk("R12 R3 flags", d, 8'hB0);
    rd(5, d); chk("R5 cleared", d, 0);

    // R4 flag without enable, then with enable
    pulse(1);
    chk("R4 no enable irq", irq_oe, 0);
    wr(0, 8'h40);
    #1 chk("R4 enabled irq", irq_oe, 1);
    chk("R4 irq_n low", irq_n, 0);
    rd(5, d); chk("R4 pfail flag", d, 8'h20);
    #1 chk("R5 irq released", irq_oe, 0);
    pulse(0); wr(0, 8'h00);
    #1 chk("R4 wdog no irq", irq_oe, 0);
    rd(5, d);

    // R5 event coincident with clear
    @(negedge clk); reg_sel = 5; reg_rd = 1; wdog_evt = 1;
    @(negedge clk); reg_rd = 0; wdog_evt = 0;
    rd(5, d); chk("R5 coincident event kept", d, 8'h80);

    // R6 binary periodic rates with random offsets
    for (int c = 3; c < 16; c++) begin
      int p, off, r;
      p = bin_period(c);
      wr(0, 8'(8'h10 | c));
      off = int'($urandom_range(0, p / 2));
      for (int i = 0; i < off; i++) pulse(4);
      rd(5, d);
      r = p - (n32 % p);
      for (int i = 0; i < r - 1; i++) pulse(4);
      rd(5, d); chk($sformatf("R6 code %0d before", c), d, 0);
      pulse(4);
      #1 chk($sformatf("R6 code %0d irq", c), irq_oe, 1);
      rd(5, d); chk($sformatf("R6 code %0d hit", c), d, 8'h08);
    end

    // R7 decimal rates and off
    wr(0, 8'h01); rd(5, d);
    pulse(5); rd(5, d); chk("R7 10ms", d, 8'h08);
    wr(0, 8'h02); rd(5, d);
    begin
      int r;
      r = 10 - (nh % 10);
      for (int i = 0; i < r - 1; i++) pulse(5);
      rd(5, d); chk("R7 100ms before", d, 0);
      pulse(5); rd(5, d); chk("R7 100ms hit", d, 8'h08);
    end
    wr(0, 8'h00); rd(5, d);
    for (int i = 0; i < 40; i++) begin pulse(4); pulse(5); end
    rd(5, d); chk("R7 code 0 silent", d, 0);

    // R9 matching time without update strobe
    a = '{8'h30, 8'h15, 8'h08, 8'h21};
    for (int i = 0; i < 4; i++) wr(3'(i + 1), a[i]);
    set_time(a);
    repeat (3) @(negedge clk);
    rd(5, d); chk("R9 no strobe", d, 0);
    pulse(3); rd(5, d); chk("R9 strobe hit", d, 8'h40);

    // R8 random alarm masks and times
    for (int it = 0; it < 250; it++) begin
      bit e;
      case ($urandom_range(0, 5))
        0: m = 4'b1111; 1: m = 4'b1110; 2: m = 4'b1100;
        3: m = 4'b1000; 4: m = 4'b0000; default: m = 4'($urandom);
      endcase
      for (int i = 0; i < 4; i++) begin
        a[i] = {m[i], 7'($urandom_range(0, 99))};
        t[i] = ($urandom_range(0, 1) == 1) ? {1'b0, a[i][6:0]}
                                           : {1'b0, 7'($urandom_range(0, 99))};
        wr(3'(i + 1), a[i]);
      end
      set_time(t);
      e = exp_alarm(m, a, t);
      pulse(3);
      rd(5, d);
      chk($sformatf("R8 mask %b", m), d, e ? 8'h40 : 8'h00);
    end

    // R10 power-on window
    por_active = 1;
    wr(0, 8'hFF); rd(0, d); chk("R10 enables held", d, 8'h0F);
    for (int i = 0; i < 4; i++) wr(3'(i + 1), 8'h80);
    pulse(3);
    #1 chk("R10 no irq", irq_oe, 0);
    rd(5, d); chk("R10 alarm flag", d, 8'h40);
    wr(0, 8'h00);
    por_active = 0;

    // R11 battery-backup mode
    batt_mode = 1;
    wr(0, 8'hD0);
    pulse(1);
    #1 chk("R11 pfail released", irq_oe, 0);
    pulse(3);
    #1 chk("R11 no backup enable", irq_oe, 0);
    wr(0, 8'hF0);
    #1 chk("R11 backup alarm", irq_oe, 1);
    rd(5, d); chk("R11 flags", d, 8'h60);
    #1 chk("R11 released after read", irq_oe, 0);
    batt_mode = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule